// File: doc/BRIEF.md
# System Clock Gear and Power-Mode Sequencer

This block picks the state clock of a processor core and walks it through its power states. It has three sources. The first is the high-frequency oscillator divided by a programmable gear. The second is a PLL path at four times that oscillator, also divided by the gear. The third is a slow sub-clock. Software writes the gear, the clock source, the PLL enable and the kind of standby to use. A halt strobe then parks the core in one of three standby levels, and an interrupt brings it back.

The block runs on the fastest clock, which is the PLL-rate reference; the plain oscillator is that rate divided by `FC_RATIO`. It produces the state clock as a one-cycle enable pulse. The sub-clock arrives as a tick input. The block does not just divide clocks. It enforces the order of PLL switch-over and standby entry. Every forbidden request is refused, leaves the state as it was, and raises a sticky error flag. Gear and source changes wait for the end of the current state-clock period, so no short period is ever produced.

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (NORMAL), `pll_run` and `err` are 0, `osc_hi_en`, `osc_lo_en` and `periph_run` are 1, the gear is code 4, and `state_clk_en` pulses once every 128 clock cycles.
- R2: Gear codes 0..4 select divide by 1, 2, 4, 8 or 16. In NORMAL the state-clock period is FC_RATIO*2*2^code cycles, which is 8, 16, 32, 64 or 128 at the default FC_RATIO of 4. A gear write with a code of 5..7 is refused, sets `err`, and leaves the period unchanged.
- R3: A gear write takes effect only at the next `state_clk_en` pulse. The period in progress when the write occurs keeps its old length, and the following period has the new length.
- R4: A select write with `sel_val`=1 (PLL) is accepted only while the PLL is enabled. It stays pending until `pll_lock` is 1, and it is then adopted at a period boundary. After that, `mode` is 1 (NORMAL on PLL) and the period is 2*2^code cycles.
- R5: Clearing the PLL enable (`wr_pll` with `pll_val`=0) while the PLL is selected or pending is refused: `err` is set and `pll_run` stays 1. Once `sel_val`=0 (oscillator) has been adopted, the same write is accepted.
- R6: A select write with `sel_val`=2 (sub-clock) gives `mode`=2 (SLOW), with one `state_clk_en` pulse for every second `sub_tick`. While SLOW is active or pending, PLL enable writes and PLL select writes are refused, and `pll_run` does not change. A sub-clock select while the PLL is selected is also refused.
- R7: `halt_val` codes are 1 for IDLE2, 2 for IDLE1 and 3 for STOP. A halt strobe enters that standby, where `mode` is 3, 4 or 5 respectively and `state_clk_en` stays 0. IDLE2 keeps `periph_run` at 1. IDLE1 clears `periph_run` but keeps both oscillators, and the PLL if it is enabled. STOP clears `periph_run`, `osc_hi_en` and `osc_lo_en`. A halt with code 0 is refused and sets `err`.
- R8: `wake_irq` in any standby returns `mode` to the run mode that issued the halt, and the state-clock pulses resume.
- R9: A halt into STOP while the PLL is enabled is refused: `err` is set and `mode` is unchanged. STOP is therefore reachable only from NORMAL or SLOW with the PLL stopped.
- R10: `err` stays set until a cycle with `err_clr`=1 and no new refusal. All register writes made during standby are refused and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL-rate reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| wr_gear | input | 1 | Gear write strobe |
| gear_val | input | GEAR_W | Gear code |
| wr_sel | input | 1 | Clock source write strobe |
| sel_val | input | 2 | Source: 0 oscillator, 1 PLL, 2 sub-clock |
| wr_pll | input | 1 | PLL enable write strobe |
| pll_val | input | 1 | PLL enable value |
| wr_halt | input | 1 | Standby kind write strobe |
| halt_val | input | 2 | Standby kind: 1 IDLE2, 2 IDLE1, 3 STOP |
| err_clr | input | 1 | Write of 1 clears the error flag |
| halt_req | input | 1 | Halt instruction strobe |
| wake_irq | input | 1 | Interrupt wake request |
| pll_lock | input | 1 | PLL lock indication |
| state_clk_en | output | 1 | State-clock enable pulse |
| osc_hi_en | output | 1 | High-frequency oscillator enable |
| osc_lo_en | output | 1 | Sub-clock oscillator enable |
| pll_run | output | 1 | PLL enable |
| periph_run | output | 1 | Peripherals clocked |
| mode | output | 3 | 0 NORMAL, 1 NORMAL on PLL, 2 SLOW, 3 IDLE2, 4 IDLE1, 5 STOP |
| err | output | 1 | Sticky refused-request flag |

## Verification
The hardest state to reach is SLOW with the PLL still enabled. Only there can the refusal of PLL writes during SLOW be seen at `pll_run`. The stimulus enables the PLL while the oscillator is selected, moves to the sub-clock, and only then tries to clear the PLL enable and to select the PLL. From that state it halts into IDLE1 to show that the PLL keeps running in standby. A pending PLL select is held for several periods with `pll_lock` low, to show that the switch waits for lock.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [1:0] {SRC_HI = 2'd0, SRC_PLL = 2'd1, SRC_SUB = 2'd2} src_e;
  typedef enum logic [1:0] {SB_RUN, SB_IDLE2, SB_IDLE1, SB_STOP} stby_e;

  localparam logic [1:0] HALT_IDLE2 = 2'd1;
  localparam logic [1:0] HALT_IDLE1 = 2'd2;
  localparam logic [1:0] HALT_STOP  = 2'd3;

  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_PLL    = 3'd1;
  localparam logic [2:0] MODE_SLOW   = 3'd2;
  localparam logic [2:0] MODE_IDLE2  = 3'd3;
  localparam logic [2:0] MODE_IDLE1  = 3'd4;
  localparam logic [2:0] MODE_STOP   = 3'd5;
endpackage

// File: rtl/sysclk_gear_div.sv
module sysclk_gear_div
  import sysclk_pkg::*;
#(
  parameter int GEAR_MAX = 4,
  parameter int FC_RATIO = 4,
  localparam int GEAR_W  = $clog2(GEAR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sub_tick,
  input  logic              pll_lock,
  input  src_e              tgt_src,
  input  logic [GEAR_W-1:0] tgt_gear,
  output src_e              act_src,
  output logic              tick
);
  localparam int MAXP  = FC_RATIO << (GEAR_MAX + 1);
  localparam int CNT_W = $clog2(MAXP);

  logic [CNT_W-1:0]  cnt_q;
  logic              half_q;
  logic [GEAR_W-1:0] act_gear;
  src_e              src_nxt;
  logic [GEAR_W-1:0] gear_nxt;

  function automatic logic [CNT_W-1:0] reload(input src_e s, input logic [GEAR_W-1:0] g);
    int p;
    p = ((s == SRC_PLL) ? 1 : FC_RATIO) << (int'(g) + 1);
    return CNT_W'(p - 1);
  endfunction

  always_comb begin
    if (act_src == SRC_SUB) tick = run && sub_tick && half_q;
    else                    tick = run && (cnt_q == '0);
  end

  always_comb begin
    src_nxt  = act_src;
    gear_nxt = act_gear;
    if (tick) begin
      gear_nxt = tgt_gear;
      if ((tgt_src != act_src) && ((tgt_src != SRC_PLL) || pll_lock))
        src_nxt = tgt_src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_src  <= SRC_HI;
      act_gear <= GEAR_W'(GEAR_MAX);
      cnt_q    <= reload(SRC_HI, GEAR_W'(GEAR_MAX));
      half_q   <= 1'b0;
    end else if (!run) begin
      cnt_q  <= reload(act_src, act_gear);
      half_q <= 1'b0;
    end else begin
      act_src  <= src_nxt;
      act_gear <= gear_nxt;
      if (tick) begin
        cnt_q  <= reload(src_nxt, gear_nxt);
        half_q <= 1'b0;
      end else if (act_src != SRC_SUB) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (sub_tick) begin
        half_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysclk_req_filter.sv
module sysclk_req_filter
  import sysclk_pkg::*;
#(
  parameter int GEAR_MAX = 4,
  localparam int GEAR_W  = $clog2(GEAR_MAX + 1)
) (
  input  logic              running,
  input  src_e              act_src,
  input  src_e              tgt_src,
  input  logic              pll_en_q,
  input  logic [1:0]        halt_sel_q,
  input  logic              wr_gear,
  input  logic [GEAR_W-1:0] gear_val,
  input  logic              wr_sel,
  input  logic [1:0]        sel_val,
  input  logic              wr_pll,
  input  logic              pll_val,
  input  logic              wr_halt,
  input  logic              halt_req,
  output logic              ok_gear,
  output logic              ok_sel,
  output logic              ok_pll,
  output logic              ok_halt_wr,
  output logic              ok_halt,
  output logic              bad
);
  logic in_slow;
  logic pll_busy;

  assign in_slow  = (act_src == SRC_SUB) || (tgt_src == SRC_SUB);
  assign pll_busy = (act_src == SRC_PLL) || (tgt_src == SRC_PLL);

  always_comb begin
    ok_gear    = running && (int'(gear_val) <= GEAR_MAX);
    ok_pll     = running && !in_slow && (pll_val || !pll_busy);
    ok_halt_wr = running;
    ok_halt    = running && (halt_sel_q != 2'd0) &&
                 !((halt_sel_q == HALT_STOP) && pll_en_q);
    case (sel_val)
      2'd0:    ok_sel = running;
      2'd1:    ok_sel = running && !in_slow && pll_en_q;
      2'd2:    ok_sel = running && !pll_busy;
      default: ok_sel = 1'b0;
    endcase
    bad = (wr_gear && !ok_gear) || (wr_sel && !ok_sel) || (wr_pll && !ok_pll) ||
          (wr_halt && !ok_halt_wr) || (halt_req && running && !ok_halt);
  end
endmodule

// File: rtl/sysclk_stby_fsm.sv
module sysclk_stby_fsm
  import sysclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_go,
  input  logic [1:0] halt_sel,
  input  logic       wake_irq,
  output stby_e      stby
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stby <= SB_RUN;
    end else begin
      case (stby)
        SB_RUN: begin
          if (halt_go) begin
            case (halt_sel)
              HALT_IDLE1: stby <= SB_IDLE1;
              HALT_STOP:  stby <= SB_STOP;
              default:    stby <= SB_IDLE2;
            endcase
          end
        end
        default: if (wake_irq) stby <= SB_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter int GEAR_MAX = 4,
  parameter int FC_RATIO = 4,
  localparam int GEAR_W  = $clog2(GEAR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_tick,
  input  logic              wr_gear,
  input  logic [GEAR_W-1:0] gear_val,
  input  logic              wr_sel,
  input  logic [1:0]        sel_val,
  input  logic              wr_pll,
  input  logic              pll_val,
  input  logic              wr_halt,
  input  logic [1:0]        halt_val,
  input  logic              err_clr,
  input  logic              halt_req,
  input  logic              wake_irq,
  input  logic              pll_lock,
  output logic              state_clk_en,
  output logic              osc_hi_en,
  output logic              osc_lo_en,
  output logic              pll_run,
  output logic              periph_run,
  output logic [2:0]        mode,
  output logic              err
);
  logic [GEAR_W-1:0] tgt_gear;
  src_e              tgt_src;
  src_e              act_src;
  logic              pll_en_q;
  logic [1:0]        halt_sel_q;
  logic              err_q;
  stby_e             stby;
  logic              running;
  logic ok_gear, ok_sel, ok_pll, ok_halt_wr, ok_halt, bad;

  assign running = (stby == SB_RUN);

  sysclk_req_filter #(.GEAR_MAX(GEAR_MAX)) u_filter (
    .running(running), .act_src(act_src), .tgt_src(tgt_src), .pll_en_q(pll_en_q),
    .halt_sel_q(halt_sel_q), .wr_gear(wr_gear), .gear_val(gear_val), .wr_sel(wr_sel),
    .sel_val(sel_val), .wr_pll(wr_pll), .pll_val(pll_val), .wr_halt(wr_halt),
    .halt_req(halt_req), .ok_gear(ok_gear), .ok_sel(ok_sel), .ok_pll(ok_pll),
    .ok_halt_wr(ok_halt_wr), .ok_halt(ok_halt), .bad(bad)
  );

  sysclk_gear_div #(.GEAR_MAX(GEAR_MAX), .FC_RATIO(FC_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running), .sub_tick(sub_tick), .pll_lock(pll_lock),
    .tgt_src(tgt_src), .tgt_gear(tgt_gear), .act_src(act_src), .tick(state_clk_en)
  );

  sysclk_stby_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_go(halt_req && ok_halt), .halt_sel(halt_sel_q),
    .wake_irq(wake_irq), .stby(stby)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_gear   <= GEAR_W'(GEAR_MAX);
      tgt_src    <= SRC_HI;
      pll_en_q   <= 1'b0;
      halt_sel_q <= HALT_IDLE2;
      err_q      <= 1'b0;
    end else begin
      if (wr_gear && ok_gear)   tgt_gear   <= gear_val;
      if (wr_sel && ok_sel)     tgt_src    <= src_e'(sel_val);
      if (wr_pll && ok_pll)     pll_en_q   <= pll_val;
      if (wr_halt && ok_halt_wr) halt_sel_q <= halt_val;
      if (bad)          err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (stby)
      SB_IDLE2: mode = MODE_IDLE2;
      SB_IDLE1: mode = MODE_IDLE1;
      SB_STOP:  mode = MODE_STOP;
      default: begin
        case (act_src)
          SRC_PLL: mode = MODE_PLL;
          SRC_SUB: mode = MODE_SLOW;
          default: mode = MODE_NORMAL;
        endcase
      end
    endcase
  end

  assign osc_hi_en  = (stby != SB_STOP);
  assign osc_lo_en  = (stby != SB_STOP);
  assign periph_run = (stby == SB_RUN) || (stby == SB_IDLE2);
  assign pll_run    = pll_en_q;
  assign err        = err_q;
endmodule

// File: rtl/sysclk_mode_ctrl_chk.sv
module sysclk_mode_ctrl_chk
  import sysclk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_pll,
  input logic       err_clr,
  input logic       wake_irq,
  input logic       state_clk_en,
  input logic       osc_hi_en,
  input logic       osc_lo_en,
  input logic       pll_run,
  input logic       periph_run,
  input logic [2:0] mode,
  input logic       err
);
  logic [2:0] last_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_run_q <= MODE_NORMAL;
    else if (mode <= MODE_SLOW) last_run_q <= mode;
  end

  AST_STOP_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode == MODE_STOP) |-> !pll_run); // R9
  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(mode == MODE_STOP) |-> ($past(mode) == MODE_NORMAL || $past(mode) == MODE_SLOW)); // R9
  AST_TICK_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n) state_clk_en |-> (mode <= MODE_SLOW)); // R7
  AST_DEEP_NO_PERIPH: assert property (@(posedge clk) disable iff (!rst_n) (mode == MODE_IDLE1 || mode == MODE_STOP) |-> !periph_run); // R7
  AST_STOP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode == MODE_STOP) |-> (!osc_hi_en && !osc_lo_en)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err && !err_clr) |=> err); // R10
  AST_PLL_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $fell(pll_run) |-> ($past(mode) == MODE_NORMAL)); // R5
  AST_PLL_MODE_HAS_PLL: assert property (@(posedge clk) disable iff (!rst_n) (mode == MODE_PLL) |-> pll_run); // R4
  AST_SLOW_PLL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (mode == MODE_SLOW && wr_pll) |=> $stable(pll_run)); // R6
  AST_WAKE_RETURN: assert property (@(posedge clk) disable iff (!rst_n) (mode > MODE_SLOW && wake_irq) |=> (mode == last_run_q)); // R8
endmodule

bind sysclk_mode_ctrl sysclk_mode_ctrl_chk u_chk (.*);

// File: tb/sysclk_mode_ctrl_test.sv
module sysclk_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0;
  logic wr_gear = 0, wr_sel = 0, wr_pll = 0, pll_val = 0, wr_halt = 0;
  logic err_clr = 0, halt_req = 0, wake_irq = 0, pll_lock = 0;
  logic [2:0] gear_val = '0;
  logic [1:0] sel_val = '0, halt_val = '0;
  logic state_clk_en, osc_hi_en, osc_lo_en, pll_run, periph_run, err;
  logic [2:0] mode;
  int checks = 0;
  int errors = 0;
  int subc = 0;

  sysclk_mode_ctrl uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (subc == 19) begin subc = 0; sub_tick = 1'b1; end
    else begin subc = subc + 1; sub_tick = 1'b0; end
  end

  // pll select flag, gear code, expected period in cycles
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    16'h0008, 16'h0110, 16'h0220, 16'h0340, 16'h0480,
    16'h1002, 16'h1104, 16'h1208, 16'h1310, 16'h1420};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (state_clk_en !== 1'b1);
  endtask

  task automatic settle();
    wait_tick();
    @(negedge clk);
  endtask

  task automatic measure(output int p);
    int n;
    wait_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (state_clk_en !== 1'b1);
    p = n;
  endtask

  task automatic w_gear(input int g);
    @(negedge clk); wr_gear = 1; gear_val = 3'(g);
    @(negedge clk); wr_gear = 0;
  endtask
  task automatic w_sel(input int s);
    @(negedge clk); wr_sel = 1; sel_val = 2'(s);
    @(negedge clk); wr_sel = 0;
  endtask
  task automatic w_pll(input logic v);
    @(negedge clk); wr_pll = 1; pll_val = v;
    @(negedge clk); wr_pll = 0;
  endtask
  task automatic w_halt(input int h);
    @(negedge clk); wr_halt = 1; halt_val = 2'(h);
    @(negedge clk); wr_halt = 0;
  endtask
  task automatic do_halt();
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
  endtask
  task automatic do_wake();
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
  endtask
  task automatic clr_err();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic count_ticks(input int cycles, output int t);
    t = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (state_clk_en) t++;
    end
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, n, t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode, 0);
    check("R1 err", err, 0);
    check("R1 pll_run", pll_run, 0);
    check("R1 osc_hi_en", osc_hi_en, 1);
    check("R1 osc_lo_en", osc_lo_en, 1);
    check("R1 periph_run", periph_run, 1);
    measure(p);
    check("R1 reset period", p, 128);

    // R2 / R4 gear table, oscillator then PLL
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12] && mode != 3'd1) begin
        w_pll(1'b1);
        w_sel(1);
        check("R4 select accepted", err, 0);
        count_ticks(300, t);
        check("R4 pending without lock", mode, 0);
        pll_lock = 1'b1;
        settle();
        check("R4 adopted after lock", mode, 1);
      end
      w_gear(int'(VEC[i][11:8]));
      wait_tick();
      measure(p);
      check(VEC[i][12] ? "R4 pll gear period" : "R2 gear period", p, int'(VEC[i][7:0]));
    end

    // R5 leave PLL order, R9 no STOP from PLL, R6 no sub from PLL, R10 clear
    w_pll(1'b0);
    check("R5 clear refused err", err, 1);
    check("R5 pll stays on", pll_run, 1);
    clr_err();
    check("R10 err cleared", err, 0);
    w_halt(3);
    do_halt();
    check("R9 stop from pll refused err", err, 1);
    check("R9 mode unchanged", mode, 1);
    clr_err();
    w_sel(2);
    check("R6 sub from pll refused", err, 1);
    clr_err();
    w_sel(0);
    settle();
    check("R5 back to normal", mode, 0);
    w_pll(1'b0);
    check("R5 clear accepted", pll_run, 0);
    check("R5 no err", err, 0);

    // R3 gear boundary
    w_gear(2);
    wait_tick(); wait_tick();
    wait_tick();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 3) begin wr_gear = 1; gear_val = 3'd0; end
      if (n == 4) wr_gear = 0;
    end while (state_clk_en !== 1'b1);
    check("R3 period in progress keeps old length", n, 32);
    measure(p);
    check("R3 next period new length", p, 8);

    // R6 SLOW with PLL enabled
    w_pll(1'b1);
    w_sel(2);
    settle();
    check("R6 slow mode", mode, 2);
    measure(p);
    check("R6 slow period", p, 40);
    w_pll(1'b0);
    check("R6 pll write refused", err, 1);
    check("R6 pll unchanged", pll_run, 1);
    clr_err();
    w_sel(1);
    check("R6 pll select refused", err, 1);
    clr_err();

    // R7 IDLE1 from SLOW, R10 write in standby, R8 wake
    w_halt(2);
    do_halt();
    check("R7 idle1 mode", mode, 4);
    check("R7 idle1 periph off", periph_run, 0);
    check("R7 idle1 osc on", osc_hi_en, 1);
    check("R7 idle1 pll kept", pll_run, 1);
    count_ticks(100, t);
    check("R7 no ticks in idle1", t, 0);
    w_gear(3);
    check("R10 standby write refused", err, 1);
    clr_err();
    do_wake();
    check("R8 wake to slow", mode, 2);
    w_sel(0);
    settle();
    check("R6 slow to normal", mode, 0);
    w_pll(1'b0);
    measure(p);
    check("R10 standby gear write ignored", p, 8);

    // R7 halt codes
    w_halt(0);
    do_halt();
    check("R7 halt code 0 refused", err, 1);
    check("R7 halt code 0 mode", mode, 0);
    clr_err();
    w_halt(1);
    do_halt();
    check("R7 idle2 mode", mode, 3);
    check("R7 idle2 periph on", periph_run, 1);
    do_wake();
    check("R8 wake from idle2", mode, 0);
    w_halt(3);
    do_halt();
    check("R9 stop mode", mode, 5);
    check("R7 stop osc_hi off", osc_hi_en, 0);
    check("R7 stop osc_lo off", osc_lo_en, 0);
    check("R7 stop periph off", periph_run, 0);
    count_ticks(50, t);
    check("R7 no ticks in stop", t, 0);
    do_wake();
    check("R8 wake from stop", mode, 0);
    measure(p);
    check("R8 ticks resume", p, 8);

    // R2 illegal gear code
    w_gear(5);
    check("R2 gear 5 refused", err, 1);
    wait_tick();
    measure(p);
    check("R2 period unchanged", p, 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule